// File: doc/BRIEF.md
# Fetch Target Predictor with Return Stack

This block sits in the fetch stage and chooses the address to fetch next. Every fetch address is looked up, at the same time as instruction memory, in a direct-mapped table of branch targets. Each entry carries a valid bit, a tag taken from the fetch address and a target address. A matching tag marks the instruction at that address as a branch. When the direction input also says taken, the stored target becomes the next fetch address. Otherwise fetch moves on to the next sequential word.

Pre-decode flags mark calls and returns. A call saves the address after itself on a small circular return stack. A return takes its target from the top of that stack, ahead of anything the table says. An empty stack falls back to the sequential address. The execute stage reports each resolved control transfer through an update port. It gives the branch address, the resolved target, the resolved direction and the target that fetch had predicted. The table is rewritten only when a taken branch went somewhere other than the predicted target.

Top module: `fetch_target_predictor`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty, so `btb_hit` is 0 and `next_pc` is `fetch_pc`+4 for any address, including a return.
- R2: The table index is `fetch_pc[IDX_W+1:2]`. The tag is the remaining address bits. `btb_hit` is 1 exactly when the indexed entry is valid and its tag matches. On a hit with `dir_taken`=1, `next_pc` is the stored target. On a hit with `dir_taken`=0, `next_pc` is `fetch_pc`+4. An address with the same index and a different tag misses.
- R3: An entry is written on a clock edge only when `upd_valid`, `upd_taken` and `upd_target != upd_pred_target` all hold. A not-taken update, or one whose target equals the predicted target, leaves the table unchanged.
- R4: When there is no hit and no return, `next_pc` is `fetch_pc`+4.
- R5: A fetch with `fetch_is_call`=1 and `fetch_is_ret`=0 pushes `fetch_pc`+4 onto the return stack at the clock edge.
- R6: A fetch with `fetch_is_ret`=1 and a non-empty stack sets `next_pc` to the most recently pushed value that has not yet been popped, and pops it at the edge. This holds even when the table hits.
- R7: A return on an empty stack gives `next_pc` = `fetch_pc`+4, whatever the table holds.
- R8: The stack holds `RAS_DEPTH` entries. A push onto a full stack overwrites the oldest entry, and the count stays at `RAS_DEPTH`.
- R9: A lookup in the same cycle as a write to the same index sees the old entry. The new entry is visible from the next cycle.
- R10: When `fetch_is_call` and `fetch_is_ret` are both 1, only the return acts and nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Current fetch address |
| fetch_is_call | input | 1 | Pre-decode: instruction at fetch_pc is a call |
| fetch_is_ret | input | 1 | Pre-decode: instruction at fetch_pc is a return |
| dir_taken | input | 1 | Direction prediction for fetch_pc |
| upd_valid | input | 1 | Execute reports a resolved control transfer |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target |
| upd_pred_target | input | PC_W | Target that fetch predicted for it |
| next_pc | output | PC_W | Predicted next fetch address |
| btb_hit | output | 1 | Tag hit in the target table |

## Verification
The case that is hardest to reach from the ports is the return stack after it has wrapped. Five calls are needed on a four-deep stack before the pops can show that the oldest entry was lost and that the fifth pop falls back to the sequential address. The bench drives that sequence and checks each popped address in turn. It also drives a write and a lookup to the same index in one cycle, both for a first write and for a retarget. This shows that the old contents are returned and the new target is visible one cycle later.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int unsigned FP_PC_W     = 32;
  localparam int unsigned FP_IDX_W    = 4;
  localparam int unsigned FP_RAS_DEPTH = 4;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BUF = 2'd1,
    SRC_RAS = 2'd2
  } nxt_src_e;
endpackage

// File: rtl/tgt_buffer.sv
module tgt_buffer #(
  parameter int unsigned PC_W  = fp_pkg::FP_PC_W,
  parameter int unsigned IDX_W = fp_pkg::FP_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] look_pc,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target,
  output logic            hit,
  output logic [PC_W-1:0] hit_target
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TAG_W   = PC_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
  } pc_split_t;

  // Index from word-address bits; tag is everything else, byte offset included.
  function automatic pc_split_t split_pc(input logic [PC_W-1:0] pc);
    pc_split_t s;
    s.idx = pc[IDX_W+1:2];
    s.tag = {pc[PC_W-1:IDX_W+2], pc[1:0]};
    return s;
  endfunction

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  pc_split_t look_s, wr_s;
  assign look_s = split_pc(look_pc);
  assign wr_s   = split_pc(wr_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_s.idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_s.idx] <= wr_s.tag;
      tgt_q[wr_s.idx] <= wr_target;
    end
  end

  assign hit        = vld_q[look_s.idx] && (tag_q[look_s.idx] == look_s.tag);
  assign hit_target = tgt_q[look_s.idx];
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned PC_W  = fp_pkg::FP_PC_W,
  parameter int unsigned DEPTH = fp_pkg::FP_RAS_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [PC_W-1:0]            push_val,
  output logic [PC_W-1:0]            top_val,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic [PC_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q;      // next free slot
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (pop && cnt_q != '0) begin
      wp_q  <= ptr_prev(wp_q);
      cnt_q <= cnt_q - 1'b1;
    end else if (push) begin
      wp_q  <= ptr_next(wp_q);
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pop) mem_q[wp_q] <= push_val;
  end

  assign top_val = mem_q[ptr_prev(wp_q)];
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
endmodule

// File: rtl/next_pc_sel.sv
module next_pc_sel
  import fp_pkg::*;
#(
  parameter int unsigned PC_W = FP_PC_W
) (
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            is_ret,
  input  logic            ras_empty,
  input  logic [PC_W-1:0] ras_top,
  input  logic            buf_hit,
  input  logic            dir_taken,
  input  logic [PC_W-1:0] buf_target,
  output logic [PC_W-1:0] next_pc,
  output nxt_src_e        src
);
  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  always_comb begin
    if (is_ret) begin
      src = ras_empty ? SRC_SEQ : SRC_RAS;
    end else if (buf_hit && dir_taken) begin
      src = SRC_BUF;
    end else begin
      src = SRC_SEQ;
    end
    unique case (src)
      SRC_RAS: next_pc = ras_top;
      SRC_BUF: next_pc = buf_target;
      default: next_pc = seq_pc(fetch_pc);
    endcase
  end
endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor
  import fp_pkg::*;
#(
  parameter int unsigned PC_W      = FP_PC_W,
  parameter int unsigned IDX_W     = FP_IDX_W,
  parameter int unsigned RAS_DEPTH = FP_RAS_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_is_call,
  input  logic            fetch_is_ret,
  input  logic            dir_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic [PC_W-1:0] upd_pred_target,
  output logic [PC_W-1:0] next_pc,
  output logic            btb_hit
);
  localparam int unsigned CNT_W = $clog2(RAS_DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic             buf_write;
  logic             ras_push;
  logic             ras_pop;
  logic             ras_empty;
  logic [CNT_W-1:0] ras_count;
  logic [PC_W-1:0]  ras_top;
  logic [PC_W-1:0]  hit_target;
  nxt_src_e         sel_src;

  assign buf_write = upd_valid && upd_taken && (upd_target != upd_pred_target);
  assign ras_push  = fetch_is_call && !fetch_is_ret;
  assign ras_pop   = fetch_is_ret;

  tgt_buffer #(.PC_W(PC_W), .IDX_W(IDX_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_pc    (fetch_pc),
    .wr_en      (buf_write),
    .wr_pc      (upd_pc),
    .wr_target  (upd_target),
    .hit        (btb_hit),
    .hit_target (hit_target)
  );

  ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ras_push),
    .pop      (ras_pop),
    .push_val (fetch_pc + PC_W'(4)),
    .top_val  (ras_top),
    .empty    (ras_empty),
    .count    (ras_count)
  );

  next_pc_sel #(.PC_W(PC_W)) u_sel (
    .fetch_pc   (fetch_pc),
    .is_ret     (fetch_is_ret),
    .ras_empty  (ras_empty),
    .ras_top    (ras_top),
    .buf_hit    (btb_hit),
    .dir_taken  (dir_taken),
    .buf_target (hit_target),
    .next_pc    (next_pc),
    .src        (sel_src)
  );
endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned RAS_DEPTH = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [PC_W-1:0]                fetch_pc,
  input logic                           fetch_is_call,
  input logic                           fetch_is_ret,
  input logic                           dir_taken,
  input logic                           upd_valid,
  input logic                           upd_taken,
  input logic [PC_W-1:0]                upd_target,
  input logic [PC_W-1:0]                upd_pred_target,
  input logic [PC_W-1:0]                next_pc,
  input logic                           btb_hit,
  input logic                           buf_write,
  input logic                           ras_push,
  input logic                           ras_empty,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_count,
  input logic [PC_W-1:0]                hit_target
);
  localparam int unsigned CNT_W = $clog2(RAS_DEPTH + 1);

  a_r4_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!btb_hit && !fetch_is_ret) |-> next_pc == fetch_pc + PC_W'(4));

  a_r2_hit_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (btb_hit && dir_taken && !fetch_is_ret) |-> next_pc == hit_target);

  a_r3_write_cond: assert property (@(posedge clk) disable iff (!rst_n)
    buf_write |-> (upd_valid && upd_taken && upd_target != upd_pred_target));

  a_r7_underflow_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_is_ret && ras_empty) |-> next_pc == fetch_pc + PC_W'(4));

  a_r5_push_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_push && ras_count != CNT_W'(RAS_DEPTH)) |=> ras_count == $past(ras_count) + 1'b1);

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_push && ras_count == CNT_W'(RAS_DEPTH)) |=> ras_count == CNT_W'(RAS_DEPTH));

  a_r6_pop_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_is_ret && !ras_empty) |=> ras_count == $past(ras_count) - 1'b1);

  a_r10_ret_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_is_call && fetch_is_ret) |-> !ras_push);
endmodule

bind fetch_target_predictor fp_checker #(.PC_W(PC_W), .RAS_DEPTH(RAS_DEPTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fetch_pc        (fetch_pc),
  .fetch_is_call   (fetch_is_call),
  .fetch_is_ret    (fetch_is_ret),
  .dir_taken       (dir_taken),
  .upd_valid       (upd_valid),
  .upd_taken       (upd_taken),
  .upd_target      (upd_target),
  .upd_pred_target (upd_pred_target),
  .next_pc         (next_pc),
  .btb_hit         (btb_hit),
  .buf_write       (buf_write),
  .ras_push        (ras_push),
  .ras_empty       (ras_empty),
  .ras_count       (ras_count),
  .hit_target      (hit_target)
);

// File: tb/sim_fetch_target_predictor.sv
`timescale 1ns/1ps
module sim_fetch_target_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_is_call = 1'b0, fetch_is_ret = 1'b0, dir_taken = 1'b0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0, upd_pred_target = '0;
  logic [31:0] next_pc;
  logic        btb_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_target_predictor u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs are applied 1 ns after a rising edge; outputs sampled 1 ns later.
  task automatic fetch(input logic [31:0] pc, input bit call, input bit ret, input bit tk);
    fetch_pc = pc; fetch_is_call = call; fetch_is_ret = ret; dir_taken = tk;
  endtask

  task automatic update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                        input logic [31:0] pred);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_pred_target = pred;
  endtask

  task automatic advance();
    @(posedge clk); #1;
    fetch_is_call = 1'b0; fetch_is_ret = 1'b0; dir_taken = 1'b0; upd_valid = 1'b0;
    fetch_pc = 32'h0000_0F00;
  endtask

  task automatic t_reset();
    fetch(32'h100, 0, 0, 1); #1;
    chk("R1 hit after reset", {31'd0, btb_hit}, 32'd0);
    chk("R1 next after reset", next_pc, 32'h104);
    fetch(32'h200, 0, 1, 1); #1;
    chk("R1 return on empty stack", next_pc, 32'h204);
    advance();
  endtask

  task automatic t_first_write();
    update(32'h1000, 1, 32'h2000, 32'h1004);
    fetch(32'h1000, 0, 0, 1); #1;
    chk("R9 same-cycle lookup old hit", {31'd0, btb_hit}, 32'd0);
    chk("R9 same-cycle lookup old next", next_pc, 32'h1004);
    advance();
    fetch(32'h1000, 0, 0, 1); #1;
    chk("R2 hit flag", {31'd0, btb_hit}, 32'd1);
    chk("R2 taken hit target", next_pc, 32'h2000);
    fetch(32'h1000, 0, 0, 0); #1;
    chk("R2 hit not taken flag", {31'd0, btb_hit}, 32'd1);
    chk("R2 hit not taken next", next_pc, 32'h1004);
    fetch(32'h1040, 0, 0, 1); #1;
    chk("R2 alias same index other tag", {31'd0, btb_hit}, 32'd0);
    chk("R4 alias falls to sequential", next_pc, 32'h1044);
  endtask

  task automatic t_write_filter();
    update(32'h1008, 0, 32'h3000, 32'h100C);
    advance();
    fetch(32'h1008, 0, 0, 1); #1;
    chk("R3 not-taken update ignored", next_pc, 32'h100C);
    update(32'h1008, 1, 32'h3000, 32'h3000);
    advance();
    fetch(32'h1008, 0, 0, 1); #1;
    chk("R3 same-target update ignored", {31'd0, btb_hit}, 32'd0);
    update(32'h1008, 1, 32'h3000, 32'h100C);
    advance();
    fetch(32'h1008, 0, 0, 1); #1;
    chk("R3 changed-target update written", next_pc, 32'h3000);
    advance();
  endtask

  task automatic t_retarget();
    update(32'h1000, 1, 32'h2200, 32'h2000);
    fetch(32'h1000, 0, 0, 1); #1;
    chk("R9 retarget same cycle old", next_pc, 32'h2000);
    advance();
    fetch(32'h1000, 0, 0, 1); #1;
    chk("R9 retarget next cycle new", next_pc, 32'h2200);
    advance();
  endtask

  task automatic t_call_ret();
    fetch(32'h500, 1, 0, 0); #1;
    chk("R5 call itself sequential", next_pc, 32'h504);
    advance();
    fetch(32'h600, 1, 0, 0); advance();
    fetch(32'h700, 0, 1, 0); #1;
    chk("R6 first pop newest", next_pc, 32'h604);
    advance();
    fetch(32'h710, 0, 1, 0); #1;
    chk("R6 second pop", next_pc, 32'h504);
    advance();
    fetch(32'h720, 0, 1, 0); #1;
    chk("R7 underflow sequential", next_pc, 32'h724);
    advance();
    fetch(32'h800, 1, 0, 0); advance();
    fetch(32'h1000, 0, 1, 1); #1;
    chk("R6 stack beats table hit", next_pc, 32'h804);
    advance();
    fetch(32'h1000, 0, 1, 1); #1;
    chk("R7 underflow ignores table hit", next_pc, 32'h1004);
    advance();
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= 5; i++) begin
      fetch(32'h10 * i, 1, 0, 0); advance();
    end
    for (int i = 5; i >= 2; i--) begin
      fetch(32'h900 + i, 0, 1, 0); #1;
      chk("R8 wrapped pop order", next_pc, 32'h10 * i + 4);
      advance();
    end
    fetch(32'hA00, 0, 1, 0); #1;
    chk("R8 oldest entry overwritten", next_pc, 32'hA04);
    advance();
  endtask

  task automatic t_both_flags();
    fetch(32'h880, 1, 0, 0); advance();
    fetch(32'h900, 1, 1, 0); #1;
    chk("R10 both flags acts as return", next_pc, 32'h884);
    advance();
    fetch(32'h910, 0, 1, 0); #1;
    chk("R10 no push from both flags", next_pc, 32'h914);
    advance();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_first_write();
    t_write_filter();
    t_retarget();
    t_call_ret();
    t_overflow();
    t_both_flags();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule